// File: doc/BRIEF.md
# Power-of-Two Scale Calibrator

The calibrator sits beside a quantizing datapath and watches a stream of IEEE single-precision values arriving in groups, where a group is one weight tile or one activation token and its final beat carries a `last` flag. For every group it keeps the largest magnitude seen. When the group closes, it turns that magnitude into a signed exponent `s` so that `amax * 2^s` lands as close as possible to the largest finite value of the chosen 8-bit float format without passing it. Because the scale is a pure power of two, the downstream quantizer applies it by adding `s` to exponent fields, and no multiplier is needed.

The exponent comes from the exponent and mantissa fields of the group maximum alone. Three policies choose which maximum is used, or whether data is used at all. Static mode returns a preloaded per-tensor exponent. Dynamic mode uses the group that just closed. Delayed mode uses the maximum of the group before it. In the two data-driven modes the result is limited to a programmable window. Non-finite inputs never reach the maximum and raise a sticky error flag.

Top module: `p2s_calibrator`

## Requirements
- R1: `scale_valid` is high for exactly the one cycle after a beat with `in_valid=1` and `in_last=1`, and low in every other cycle. `scale_exp` is updated in that same cycle.
- R2: In dynamic mode, `scale_exp` is the largest integer `s` with `amax * 2^s <= FMAX`. FMAX is 448 when `fmt_sel=0` and 57344 when `fmt_sel=1`. It is formed as `T - (e - 127) - (m > 0x600000 ? 1 : 0)`, where `e` is the 8-bit exponent field of amax, `m` is its 23-bit mantissa field, and `T` is 8 or 15 for the two formats.
- R3: The sign bit (bit 31) is ignored. amax is the largest of bits [30:0] over every valid beat of the group, including the last beat. Tracking restarts from zero on the first valid beat after a last beat.
- R4: In dynamic and delayed modes, the result is limited to `[clamp_lo, clamp_hi]`, both signed, assuming `clamp_lo <= clamp_hi`.
- R5: When amax has a zero exponent field (only ±0 or subnormal inputs, or no finite inputs at all), the result is `clamp_hi`.
- R6: A valid beat whose exponent field is all ones (NaN or infinity) does not enter amax. It sets `err_sticky`, which only reset clears.
- R7: Static mode (`mode_sel=0`) returns `static_exp` unchanged, with no clamping.
- R8: Delayed mode (`mode_sel=2`) computes the result from the amax of the previous completed group. Groups completed in every mode are recorded. Before any group has completed since reset, the result is `clamp_hi`.
- R9: `mode_sel`, `fmt_sel`, `static_exp` and both clamp bounds are sampled only on the last beat of a group. `mode_sel=3` behaves as dynamic.
- R10: Beats with `in_valid=0` have no effect on amax, the error flag or the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data beat qualifier |
| in_last | input | 1 | Marks the final beat of a group |
| in_data | input | 32 | Single-precision input value |
| fmt_sel | input | 1 | Target format: 0 = 4-exponent/3-mantissa, 1 = 5-exponent/2-mantissa |
| mode_sel | input | 2 | 0 static, 1 dynamic, 2 delayed, 3 dynamic |
| static_exp | input | EXP_W | Preloaded exponent for static mode (signed) |
| clamp_lo | input | EXP_W | Lower bound of the result (signed) |
| clamp_hi | input | EXP_W | Upper bound of the result (signed) |
| scale_valid | output | 1 | One-cycle strobe for a new exponent |
| scale_exp | output | EXP_W | Signed scale exponent |
| err_sticky | output | 1 | Set once a NaN or infinity has been seen |

## Verification
The bench tests exact format maxima and values one mantissa step above them, where an off-by-one in the mantissa comparison would leave a scaled value above the format limit. Groups made only of zeros and subnormals check for a garbage exponent where `clamp_hi` is expected. NaN and infinity beats placed inside a group check that the maximum is not corrupted and that the error flag is not dropped. Delayed-mode runs right after reset check for a design that returns the current group, or stale state, in place of the previous group. Invalid beats carrying huge values, and back-to-back single-beat groups, expose trackers that sample without qualification or that fail to restart between groups.

// File: rtl/p2s_pkg.sv
package p2s_pkg;

    localparam int FP_W    = 32;
    localparam int MAG_W   = FP_W - 1;
    localparam int EXPF_W  = 8;
    localparam int MANT_W  = 23;
    localparam int FP_BIAS = 127;

    // Both 8-bit formats top out at 1.75 * 2^T
    localparam logic [MANT_W-1:0] FMT_TOP_MANT = 23'h600000;
    localparam int TOP_EXP_E4M3 = 8;
    localparam int TOP_EXP_E5M2 = 15;

    typedef logic [MAG_W-1:0] mag_t;

    typedef struct packed {
        logic [EXPF_W-1:0] expo;
        logic [MANT_W-1:0] mant;
    } mag_fields_t;

    typedef enum logic [1:0] {
        MODE_STATIC  = 2'd0,
        MODE_DYNAMIC = 2'd1,
        MODE_DELAYED = 2'd2,
        MODE_DYN_ALT = 2'd3
    } mode_e;

    typedef enum logic {
        FMT_E4M3 = 1'b0,
        FMT_E5M2 = 1'b1
    } fmt_e;

    function automatic logic is_nonfinite(input logic [FP_W-1:0] v);
        return v[FP_W-2 -: EXPF_W] == '1;
    endfunction

    function automatic int top_exp(input fmt_e f);
        return (f == FMT_E5M2) ? TOP_EXP_E5M2 : TOP_EXP_E4M3;
    endfunction

endpackage

// File: rtl/p2s_amax_track.sv
module p2s_amax_track
    import p2s_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic [FP_W-1:0] in_data,
    output mag_t            blk_amax,
    output logic            blk_done,
    output logic            bad_beat
);

    mag_t cur_amax;
    mag_t beat_mag;
    logic beat_bad;
    logic take_beat;

    always_comb begin
        beat_mag  = in_data[MAG_W-1:0];
        beat_bad  = is_nonfinite(in_data);
        take_beat = in_valid && !beat_bad && (beat_mag > cur_amax);
        blk_amax  = take_beat ? beat_mag : cur_amax;
        blk_done  = in_valid && in_last;
        bad_beat  = in_valid && beat_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_amax <= '0;
        end else if (in_valid) begin
            cur_amax <= in_last ? '0 : blk_amax;
        end
    end

endmodule

// File: rtl/p2s_exp_calc.sv
module p2s_exp_calc
    import p2s_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  mag_t                    mag,
    input  fmt_e                    fmt,
    input  logic signed [EXP_W-1:0] lo,
    input  logic signed [EXP_W-1:0] hi,
    output logic signed [EXP_W-1:0] scale
);

    mag_fields_t f;
    int          raw;
    int          lim;

    always_comb begin
        f   = mag_fields_t'(mag);
        raw = top_exp(fmt) - (int'(f.expo) - FP_BIAS)
              - ((f.mant > FMT_TOP_MANT) ? 1 : 0);
        if (f.expo == '0)
            lim = int'(hi);
        else if (raw > int'(hi))
            lim = int'(hi);
        else if (raw < int'(lo))
            lim = int'(lo);
        else
            lim = raw;
        scale = lim[EXP_W-1:0];
    end

endmodule

// File: rtl/p2s_history.sv
module p2s_history
    import p2s_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  mag_t new_amax,
    output mag_t prev_amax
);

    always_ff @(posedge clk) begin
        if (rst)
            prev_amax <= '0;
        else if (capture)
            prev_amax <= new_amax;
    end

endmodule

// File: rtl/p2s_calibrator.sv
module p2s_calibrator
    import p2s_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_last,
    input  logic [31:0]             in_data,
    input  logic                    fmt_sel,
    input  logic [1:0]              mode_sel,
    input  logic signed [EXP_W-1:0] static_exp,
    input  logic signed [EXP_W-1:0] clamp_lo,
    input  logic signed [EXP_W-1:0] clamp_hi,
    output logic                    scale_valid,
    output logic signed [EXP_W-1:0] scale_exp,
    output logic                    err_sticky
);

    mag_t  blk_amax;
    mag_t  prev_amax;
    mag_t  sel_amax;
    logic  blk_done;
    logic  bad_beat;
    mode_e mode;
    logic signed [EXP_W-1:0] calc_exp;

    p2s_amax_track u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_data  (in_data),
        .blk_amax (blk_amax),
        .blk_done (blk_done),
        .bad_beat (bad_beat)
    );

    p2s_history u_hist (
        .clk       (clk),
        .rst       (rst),
        .capture   (blk_done),
        .new_amax  (blk_amax),
        .prev_amax (prev_amax)
    );

    always_comb begin
        mode     = mode_e'(mode_sel);
        sel_amax = (mode == MODE_DELAYED) ? prev_amax : blk_amax;
    end

    p2s_exp_calc #(.EXP_W(EXP_W)) u_calc (
        .mag   (sel_amax),
        .fmt   (fmt_e'(fmt_sel)),
        .lo    (clamp_lo),
        .hi    (clamp_hi),
        .scale (calc_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_valid <= 1'b0;
            scale_exp   <= '0;
            err_sticky  <= 1'b0;
        end else begin
            scale_valid <= blk_done;
            if (blk_done)
                scale_exp <= (mode == MODE_STATIC) ? static_exp : calc_exp;
            if (bad_beat)
                err_sticky <= 1'b1;
        end
    end

endmodule

// File: rtl/p2s_checker.sv
module p2s_checker #(
    parameter int EXP_W = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_last,
    input logic [31:0]             in_data,
    input logic [1:0]              mode_sel,
    input logic signed [EXP_W-1:0] static_exp,
    input logic signed [EXP_W-1:0] clamp_lo,
    input logic signed [EXP_W-1:0] clamp_hi,
    input logic                    scale_valid,
    input logic signed [EXP_W-1:0] scale_exp,
    input logic                    err_sticky
);

    AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> scale_valid); // R1

    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> !scale_valid); // R1

    AST_CLAMP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && mode_sel != 2'd0 && clamp_lo <= clamp_hi)
        |=> (scale_exp >= $past(clamp_lo) && scale_exp <= $past(clamp_hi))); // R4

    AST_STATIC_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && mode_sel == 2'd0)
        |=> scale_exp == $past(static_exp)); // R7

    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[30:23] == 8'hFF) |=> err_sticky); // R6

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky); // R6

endmodule

bind p2s_calibrator p2s_checker #(.EXP_W(EXP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_data     (in_data),
    .mode_sel    (mode_sel),
    .static_exp  (static_exp),
    .clamp_lo    (clamp_lo),
    .clamp_hi    (clamp_hi),
    .scale_valid (scale_valid),
    .scale_exp   (scale_exp),
    .err_sticky  (err_sticky)
);

// File: tb/p2s_calibrator_test.sv
module p2s_calibrator_test;

    localparam int EXP_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic fmt_sel = 1'b0;
    logic [1:0] mode_sel = 2'd1;
    logic signed [EXP_W-1:0] static_exp = '0;
    logic signed [EXP_W-1:0] clamp_lo = -10'sd64;
    logic signed [EXP_W-1:0] clamp_hi = 10'sd64;
    logic scale_valid;
    logic signed [EXP_W-1:0] scale_exp;
    logic err_sticky;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    int unsigned m_amax = 0;
    int unsigned m_hist = 0;
    bit m_err = 0;
    bit e_valid = 0;
    int e_scale = 0;

    always #10 clk = ~clk;

    p2s_calibrator #(.EXP_W(EXP_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .fmt_sel(fmt_sel), .mode_sel(mode_sel),
        .static_exp(static_exp), .clamp_lo(clamp_lo), .clamp_hi(clamp_hi),
        .scale_valid(scale_valid), .scale_exp(scale_exp), .err_sticky(err_sticky)
    );

    function automatic int ref_scale(int unsigned mag, bit f, int lo, int hi);
        real fmax;
        real r;
        int e;
        int res;
        fmax = f ? 57344.0 : 448.0;
        e = int'((mag >> 23) & 32'hFF);
        if (e == 0) return hi;
        r = (1.0 + real'(mag & 32'h7FFFFF) / 8388608.0) * (2.0 ** (e - 127));
        res = -300;
        for (int s = 200; s >= -200; s--) begin
            if (r * (2.0 ** s) <= fmax) begin
                res = s;
                break;
            end
        end
        if (res > hi) res = hi;
        if (res < lo) res = lo;
        return res;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(scale_valid == e_valid, "R1 strobe", int'(scale_valid), int'(e_valid));
        check(err_sticky == m_err, "R6 error flag", int'(err_sticky), int'(m_err));
        if (e_valid)
            check(int'(scale_exp) == e_scale, tag, int'(scale_exp), e_scale);
    endtask

    task automatic beat(bit v, bit l, logic [31:0] d, string tag);
        int unsigned used;
        in_valid = v; in_last = l; in_data = d;
        e_valid = v && l;
        if (v && d[30:23] == 8'hFF) m_err = 1;
        else if (v && int'(d[30:0]) > int'(m_amax)) m_amax = d[30:0];
        if (v && l) begin
            used = (mode_sel == 2'd2) ? m_hist : m_amax;
            if (mode_sel == 2'd0) e_scale = int'(static_exp);
            else e_scale = ref_scale(used, fmt_sel, int'(clamp_lo), int'(clamp_hi));
            m_hist = m_amax;
            m_amax = 0;
        end
        @(posedge clk);
        #5;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 0; in_last = 0;
        repeat (2) @(posedge clk);
        #5;
        rst = 1'b0;
        m_amax = 0; m_hist = 0; m_err = 0; e_valid = 0;
        check(scale_valid == 1'b0, "R1 reset strobe", int'(scale_valid), 0);
        check(err_sticky == 1'b0, "R6 reset flag", int'(err_sticky), 0);
    endtask

    initial begin
        do_reset();
        // R2 R3 dynamic, sign ignored: amax 3.0 -> 7
        mode_sel = 2'd1; fmt_sel = 0;
        beat(1, 0, 32'h3F800000, "R3");
        beat(1, 0, 32'hC0400000, "R3");
        beat(1, 1, 32'h40200000, "R3 mixed signs");
        beat(0, 0, 32'h0, "R1 idle");
        // R2 boundaries
        beat(1, 1, 32'h43E00000, "R2 exact 448");
        beat(1, 1, 32'h43E08000, "R2 above 448");
        fmt_sel = 1;
        beat(1, 1, 32'h3F800000, "R2 wide format 1.0");
        beat(1, 1, 32'h47600000, "R2 exact 57344");
        beat(1, 1, 32'h47608000, "R2 above 57344");
        fmt_sel = 0;
        // R4 clamp
        clamp_lo = -10'sd8; clamp_hi = 10'sd20;
        beat(1, 1, 32'h2EDBE6FF, "R4 upper clamp");
        beat(1, 1, 32'h7149F2CA, "R4 lower clamp");
        // R5 zero/subnormal block
        beat(1, 0, 32'h00000000, "R5");
        beat(1, 0, 32'h80000000, "R5");
        beat(1, 1, 32'h00000001, "R5 zero block");
        clamp_lo = -10'sd64; clamp_hi = 10'sd64;
        // R6 non-finite excluded
        beat(1, 0, 32'h40000000, "R6");
        beat(1, 0, 32'h7FC00000, "R6");
        beat(1, 1, 32'h7F800000, "R6 nonfinite excluded");
        beat(1, 1, 32'h3F800000, "R6 flag holds");
        // R10 invalid beats ignored
        beat(1, 0, 32'h3F800000, "R10");
        beat(0, 0, 32'h7149F2CA, "R10");
        beat(0, 1, 32'h7F800000, "R10");
        beat(1, 1, 32'h3F800000, "R10 invalid ignored");
        // R7 static, unclamped
        mode_sel = 2'd0; static_exp = -10'sd5; clamp_lo = 10'sd0;
        beat(1, 1, 32'h3F800000, "R7 static passthrough");
        clamp_lo = -10'sd64;
        // R9 mode sampled at last beat, mode 3 dynamic
        beat(1, 0, 32'h40400000, "R9");
        mode_sel = 2'd3;
        beat(1, 1, 32'h3F800000, "R9 late mode change");
        // R3 back-to-back single beat groups restart
        mode_sel = 2'd1;
        beat(1, 1, 32'h60AD78EC, "R3 big group");
        beat(1, 1, 32'h3F800000, "R3 fresh group");
        // R8 delayed after reset
        do_reset();
        mode_sel = 2'd2;
        beat(1, 1, 32'h40400000, "R8 no history");
        beat(1, 0, 32'h43E00000, "R8");
        beat(1, 1, 32'h3F800000, "R8 previous group");
        beat(1, 1, 32'h40000000, "R8 previous group 2");
        mode_sel = 2'd1;
        beat(1, 1, 32'h42000000, "R8 history in dynamic");
        mode_sel = 2'd2;
        beat(1, 1, 32'h3F800000, "R8 history recorded");
        beat(0, 0, 32'h0, "R1 idle end");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule